// File: doc/BRIEF.md
# Flash Program/Erase Command Sequencer

This block is the command and write-sequencing side of a partitioned NOR flash. It takes one decoded command per cycle on a command port: read a word, program a word, erase a block, suspend, resume, clear status, lock a block or unlock a block. Program and erase run for a fixed number of busy cycles, which are timed by counters. At the end of that time the array stub is written. Program clears bits: the new data is ANDed into the stored word. Erase sets every word of one block to all-ones.

Erase and program each keep their own saved state, so the two suspends can nest. While an erase is suspended, a program to some other block may run, and that program may be suspended in turn. While a program is suspended, the only thing allowed is a read of another location. A seven-bit status word reports the following: whether the sequencer is ready, whether an erase or a program is suspended, and four sticky error flags. Those flags cover an erase refusal, a program refusal, a low programming supply and a locked block. A supply-OK input blocks all array changes. If that input drops while an operation is running, the operation is aborted.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the status is 7'b0000001 (only bit 0, ready, set), readData is 0, every array word reads 16'hFFFF, no block is locked and nothing is suspended.
- R2: Opcode 1 (read) returns the addressed word on readData one cycle after the command. Opcode 2 (program) ANDs cmdData into the addressed word and changes no other word.
- R3: An accepted program keeps status bit 0 low for exactly N_PROG cycles, and an accepted erase keeps it low for exactly N_ERASE cycles. The busy time starts in the cycle after the command.
- R4: Opcode 3 (erase) sets every word of the block given by cmdBlock to all-ones and leaves the other blocks untouched.
- R5: Opcode 4 (suspend) during a running erase stops the erase counter and sets status bit 1, with bit 0 high. Opcode 5 (resume) clears bit 1, and the erase then finishes after the cycles that remained.
- R6: While an erase is suspended, a program to another block runs to completion. A program to the suspended block is refused, sets status bit 4 and changes nothing. A read of the suspended block is refused and readData holds its value.
- R7: Suspend during a running program stops its counter and sets status bit 2, with bit 0 high. While the program is suspended, an erase sets bit 3 and a program sets bit 4, and neither starts. Reads of other words are served, while a read of the suspended word holds readData. Resume finishes the remaining cycles.
- R8: When a program is suspended inside a suspended erase, the first resume continues the program only, with bit 1 still set. A second resume after the program completes continues the erase.
- R9: The following are ignored and leave the status unchanged: a suspend when nothing is running, a suspend of an operation that is already suspended, and a resume when nothing is suspended.
- R10: With vppOk low, a program or erase is refused, sets status bit 5 and changes no word. If vppOk is low in a running cycle of an operation, that operation is aborted with bit 5 set and the array is unchanged.
- R11: Opcode 7 locks block cmdBlock and opcode 8 unlocks it, and the change applies to the very next command. A program or erase to a locked block sets status bit 6 and changes nothing.
- R12: Error bits 3 to 6 stay set through later successful operations until opcode 6 (clear status) clears them. Clear status leaves bits 0 to 2 as they were.
- R13: A program or erase issued while an operation is running is refused, setting bit 4 or bit 3 respectively, and the running operation is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 4 | Opcode: 1 read, 2 program, 3 erase, 4 suspend, 5 resume, 6 clear status, 7 lock, 8 unlock |
| cmdBlock | input | $clog2(NUM_BLOCKS) | Block address |
| cmdWord | input | $clog2(WORDS_PER_BLOCK) | Word address inside the block |
| cmdData | input | DATA_W | Program data |
| vppOk | input | 1 | Programming supply above lockout |
| readData | output | DATA_W | Last served read |
| status | output | 7 | {lockErr, supplyErr, progErr, eraseErr, progSusp, eraseSusp, ready} |

## Verification
The bench counts the busy cycles of an erase that is suspended partway and then resumed. A design that keeps counting while suspended, or that restarts the count from the beginning on resume, shows ready at the wrong cycle. The bench also nests a suspended program inside a suspended erase and then resumes. A design that resumes the erase first, or clears both suspend bits at once, shows the wrong status. The bench drops the supply partway through a program and reads the word back afterwards, which exposes a design that still commits the write. It also programs a block immediately after unlocking it, which exposes a lock that takes effect a cycle late.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef enum logic [3:0] {
    CMD_NOP    = 4'd0,
    CMD_READ   = 4'd1,
    CMD_PROG   = 4'd2,
    CMD_ERASE  = 4'd3,
    CMD_SUSP   = 4'd4,
    CMD_RESUME = 4'd5,
    CMD_CLRST  = 4'd6,
    CMD_LOCK   = 4'd7,
    CMD_UNLOCK = 4'd8
  } cmdOp_e;

  localparam int ST_W         = 7;
  localparam int ST_READY     = 0;
  localparam int ST_ESUSP     = 1;
  localparam int ST_PSUSP     = 2;
  localparam int ST_ERASE_ERR = 3;
  localparam int ST_PROG_ERR  = 4;
  localparam int ST_VPP_ERR   = 5;
  localparam int ST_LOCK_ERR  = 6;

  // Strobes from the sequencer control to the array datapath
  typedef struct packed {
    logic rdEn;
    logic progWe;
    logic eraseWe;
    logic lockWe;
    logic lockVal;
  } dpStrobe_t;

endpackage

// File: rtl/fcs_datapath.sv
module fcs_datapath
  import fcs_pkg::*;
#(
  parameter int NUM_BLOCKS      = 4,
  parameter int WORDS_PER_BLOCK = 8,
  parameter int DATA_W          = 16,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int WRD_W = $clog2(WORDS_PER_BLOCK)
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobe,
  input  logic [BLK_W-1:0]  cmdBlock,
  input  logic [WRD_W-1:0]  cmdWord,
  input  logic [BLK_W-1:0]  wrBlock,
  input  logic [WRD_W-1:0]  wrWord,
  input  logic [DATA_W-1:0] wrData,
  output logic              blkLocked,
  output logic [DATA_W-1:0] readData
);

  logic [DATA_W-1:0]     mem [NUM_BLOCKS][WORDS_PER_BLOCK];
  logic [NUM_BLOCKS-1:0] lockBits;

  assign blkLocked = lockBits[cmdBlock];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NUM_BLOCKS; b++)
        for (int w = 0; w < WORDS_PER_BLOCK; w++)
          mem[b][w] <= '1;
      lockBits <= '0;
      readData <= '0;
    end else begin
      if (strobe.eraseWe)
        for (int w = 0; w < WORDS_PER_BLOCK; w++)
          mem[wrBlock][w] <= '1;
      if (strobe.progWe)
        mem[wrBlock][wrWord] <= mem[wrBlock][wrWord] & wrData;
      if (strobe.lockWe)
        lockBits[cmdBlock] <= strobe.lockVal;
      if (strobe.rdEn)
        readData <= mem[cmdBlock][cmdWord];
    end
  end

endmodule

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
  import fcs_pkg::*;
#(
  parameter int NUM_BLOCKS      = 4,
  parameter int WORDS_PER_BLOCK = 8,
  parameter int DATA_W          = 16,
  parameter int N_PROG          = 4,
  parameter int N_ERASE         = 10,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int WRD_W = $clog2(WORDS_PER_BLOCK),
  localparam int CNT_W = $clog2((N_ERASE > N_PROG ? N_ERASE : N_PROG) + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdValid,
  input  logic [3:0]        cmdOp,
  input  logic [BLK_W-1:0]  cmdBlock,
  input  logic [WRD_W-1:0]  cmdWord,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              vppOk,
  input  logic              blkLocked,
  output dpStrobe_t         strobe,
  output logic [BLK_W-1:0]  wrBlock,
  output logic [WRD_W-1:0]  wrWord,
  output logic [DATA_W-1:0] wrData,
  output logic [ST_W-1:0]   status
);

  // Saved erase context
  logic             eActive, eSusp;
  logic [BLK_W-1:0] eBlock;
  logic [CNT_W-1:0] eCnt;
  // Saved program context
  logic              pActive, pSusp;
  logic [BLK_W-1:0]  pBlock;
  logic [WRD_W-1:0]  pWord;
  logic [DATA_W-1:0] pData;
  logic [CNT_W-1:0]  pCnt;
  // Sticky errors
  logic eraseErr, progErr, vppErr, lockErr;

  logic progRun, eraseRun, progAdv, eraseAdv;
  logic hitErase, hitProg, progOk, eraseOk;
  logic isRead, isProg, isErase, isSusp, isResume, isClr, isLock, isUnlock;

  always_comb begin
    isRead   = cmdValid && (cmdOp == CMD_READ);
    isProg   = cmdValid && (cmdOp == CMD_PROG);
    isErase  = cmdValid && (cmdOp == CMD_ERASE);
    isSusp   = cmdValid && (cmdOp == CMD_SUSP);
    isResume = cmdValid && (cmdOp == CMD_RESUME);
    isClr    = cmdValid && (cmdOp == CMD_CLRST);
    isLock   = cmdValid && (cmdOp == CMD_LOCK);
    isUnlock = cmdValid && (cmdOp == CMD_UNLOCK);

    progRun  = pActive && !pSusp;
    eraseRun = eActive && !eSusp && !pActive;
    // A suspend edge does not count as a busy cycle
    progAdv  = progRun && !isSusp;
    eraseAdv = eraseRun && !isSusp;

    hitErase = eActive && (cmdBlock == eBlock);
    hitProg  = pActive && (cmdBlock == pBlock) && (cmdWord == pWord);
    progOk   = !pActive && (!eActive || (eSusp && !hitErase));
    eraseOk  = !pActive && !eActive;

    strobe.rdEn    = isRead && !hitErase && !hitProg;
    strobe.progWe  = progAdv && vppOk && (pCnt == CNT_W'(1));
    strobe.eraseWe = eraseAdv && vppOk && (eCnt == CNT_W'(1));
    strobe.lockWe  = isLock || isUnlock;
    strobe.lockVal = isLock;

    wrBlock = strobe.progWe ? pBlock : eBlock;
    wrWord  = pWord;
    wrData  = pData;

    status = {lockErr, vppErr, progErr, eraseErr, pSusp, eSusp,
              !progRun && !eraseRun};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eActive <= 1'b0; eSusp <= 1'b0; eBlock <= '0; eCnt <= '0;
      pActive <= 1'b0; pSusp <= 1'b0; pBlock <= '0; pWord <= '0;
      pData <= '0; pCnt <= '0;
      eraseErr <= 1'b0; progErr <= 1'b0; vppErr <= 1'b0; lockErr <= 1'b0;
    end else begin
      // Busy-phase counting and supply abort
      if (progAdv) begin
        if (!vppOk) begin
          pActive <= 1'b0;
          vppErr  <= 1'b1;
        end else if (pCnt == CNT_W'(1)) pActive <= 1'b0;
        else pCnt <= pCnt - CNT_W'(1);
      end
      if (eraseAdv) begin
        if (!vppOk) begin
          eActive <= 1'b0;
          vppErr  <= 1'b1;
        end else if (eCnt == CNT_W'(1)) eActive <= 1'b0;
        else eCnt <= eCnt - CNT_W'(1);
      end

      // Command acceptance
      if (isProg) begin
        if (!vppOk)        vppErr  <= 1'b1;
        else if (!progOk)  progErr <= 1'b1;
        else if (blkLocked) lockErr <= 1'b1;
        else begin
          pActive <= 1'b1;
          pSusp   <= 1'b0;
          pBlock  <= cmdBlock;
          pWord   <= cmdWord;
          pData   <= cmdData;
          pCnt    <= CNT_W'(N_PROG);
        end
      end
      if (isErase) begin
        if (!vppOk)        vppErr   <= 1'b1;
        else if (!eraseOk) eraseErr <= 1'b1;
        else if (blkLocked) lockErr <= 1'b1;
        else begin
          eActive <= 1'b1;
          eSusp   <= 1'b0;
          eBlock  <= cmdBlock;
          eCnt    <= CNT_W'(N_ERASE);
        end
      end
      if (isSusp) begin
        if (progRun)       pSusp <= 1'b1;
        else if (eraseRun) eSusp <= 1'b1;
      end
      if (isResume) begin
        if (pSusp)                  pSusp <= 1'b0;
        else if (eSusp && !pActive) eSusp <= 1'b0;
      end
      if (isClr) begin
        eraseErr <= 1'b0; progErr <= 1'b0; vppErr <= 1'b0; lockErr <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int NUM_BLOCKS      = 4,
  parameter int WORDS_PER_BLOCK = 8,
  parameter int DATA_W          = 16,
  parameter int N_PROG          = 4,
  parameter int N_ERASE         = 10,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int WRD_W = $clog2(WORDS_PER_BLOCK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdValid,
  input  logic [3:0]        cmdOp,
  input  logic [BLK_W-1:0]  cmdBlock,
  input  logic [WRD_W-1:0]  cmdWord,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              vppOk,
  output logic [DATA_W-1:0] readData,
  output logic [6:0]        status
);

  dpStrobe_t         strobe;
  logic [BLK_W-1:0]  wrBlock;
  logic [WRD_W-1:0]  wrWord;
  logic [DATA_W-1:0] wrData;
  logic              blkLocked;

  fcs_ctrl #(
    .NUM_BLOCKS(NUM_BLOCKS), .WORDS_PER_BLOCK(WORDS_PER_BLOCK),
    .DATA_W(DATA_W), .N_PROG(N_PROG), .N_ERASE(N_ERASE)
  ) ctrl_i (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdBlock(cmdBlock), .cmdWord(cmdWord), .cmdData(cmdData),
    .vppOk(vppOk), .blkLocked(blkLocked), .strobe(strobe),
    .wrBlock(wrBlock), .wrWord(wrWord), .wrData(wrData), .status(status)
  );

  fcs_datapath #(
    .NUM_BLOCKS(NUM_BLOCKS), .WORDS_PER_BLOCK(WORDS_PER_BLOCK), .DATA_W(DATA_W)
  ) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe), .cmdBlock(cmdBlock),
    .cmdWord(cmdWord), .wrBlock(wrBlock), .wrWord(wrWord), .wrData(wrData),
    .blkLocked(blkLocked), .readData(readData)
  );

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker
  import fcs_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       cmdValid,
  input logic [3:0] cmdOp,
  input logic       vppOk,
  input logic [6:0] status
);

  // R12: error flags never drop without a clear-status command
  p_err_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    !(cmdValid && cmdOp == CMD_CLRST) |=>
      ((status[6:3] & $past(status[6:3])) == $past(status[6:3])));

  // R12: clear-status empties the error flags
  p_err_clear_r12: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdOp == CMD_CLRST) |=> (status[6:3] == 4'b0000));

  // R7: a suspended program means nothing is running
  p_psusp_ready_r7: assert property (@(posedge clk) disable iff (rst)
    status[ST_PSUSP] |-> status[ST_READY]);

  // R7: erase during program suspend is refused
  p_erase_refused_r7: assert property (@(posedge clk) disable iff (rst)
    (status[ST_PSUSP] && cmdValid && cmdOp == CMD_ERASE) |=> status[ST_ERASE_ERR]);

  // R9: resume with nothing suspended leaves the suspend bits clear
  p_resume_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdOp == CMD_RESUME && status[2:1] == 2'b00) |=> (status[2:1] == 2'b00));

  // R10: a program attempted with low supply flags the supply error
  p_vpp_prog_r10: assert property (@(posedge clk) disable iff (rst)
    (!vppOk && cmdValid && cmdOp == CMD_PROG) |=> status[ST_VPP_ERR]);

endmodule

bind flash_cmd_seq fcs_checker chk_i (
  .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .vppOk(vppOk), .status(status)
);

// File: tb/flash_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb_top;

  localparam int NB = 4;
  localparam int NW = 8;
  localparam int DW = 16;
  localparam int NP = 4;
  localparam int NE = 10;

  localparam logic [3:0] OP_READ = 4'd1, OP_PROG = 4'd2, OP_ERASE = 4'd3,
    OP_SUSP = 4'd4, OP_RESUME = 4'd5, OP_CLR = 4'd6, OP_LOCK = 4'd7, OP_UNLOCK = 4'd8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmdValid = 1'b0;
  logic [3:0]    cmdOp = '0;
  logic [1:0]    cmdBlock = '0;
  logic [2:0]    cmdWord = '0;
  logic [DW-1:0] cmdData = '0;
  logic          vppOk = 1'b1;
  logic [DW-1:0] readData;
  logic [6:0]    status;

  int nChecks = 0;
  int nFails  = 0;

  logic [DW-1:0] model [NB][NW];
  logic          modelLock [NB];

  always #2 clk = ~clk;

  flash_cmd_seq #(.NUM_BLOCKS(NB), .WORDS_PER_BLOCK(NW), .DATA_W(DW),
                  .N_PROG(NP), .N_ERASE(NE)) dut_i (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdBlock(cmdBlock), .cmdWord(cmdWord), .cmdData(cmdData),
    .vppOk(vppOk), .readData(readData), .status(status));

  function automatic logic [6:0] refusedStatus(input logic vpp, input logic locked);
    if (!vpp)   return 7'b0100001;
    if (locked) return 7'b1000001;
    return 7'b0000001;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(input logic [3:0] op, input int blk, input int wd, input logic [DW-1:0] d);
    cmdValid = 1'b1; cmdOp = op; cmdBlock = 2'(blk); cmdWord = 3'(wd); cmdData = d;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = '0;
  endtask

  task automatic waitReady();
    for (int i = 0; i < 40 && !status[0]; i++) @(negedge clk);
  endtask

  task automatic progDone(input int blk, input int wd, input logic [DW-1:0] d);
    issue(OP_PROG, blk, wd, d);
    waitReady();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    waitN(3);
    rst = 1'b0;
    check("R1 reset status", status, 7'b0000001);
    check("R1 reset readData", readData, 0);
    issue(OP_READ, 1, 2, 0);
    check("R1 erased after reset", readData, 16'hFFFF);

    // Program timing and AND semantics
    issue(OP_PROG, 1, 2, 16'h1234);
    check("R3 prog busy start", status[0], 0);
    waitN(NP - 1);
    check("R3 prog busy last", status[0], 0);
    waitN(1);
    check("R3 prog ready", status, 7'b0000001);
    issue(OP_READ, 1, 2, 0);
    check("R2 read programmed", readData, 16'h1234);
    progDone(1, 2, 16'hFF0F);
    issue(OP_READ, 1, 2, 0);
    check("R2 AND into word", readData, 16'h1204);
    issue(OP_READ, 1, 3, 0);
    check("R2 neighbour untouched", readData, 16'hFFFF);

    // Erase timing and scope
    progDone(0, 0, 16'h0000);
    issue(OP_ERASE, 1, 0, 0);
    waitN(NE - 1);
    check("R3 erase busy last", status[0], 0);
    waitN(1);
    check("R3 erase ready", status, 7'b0000001);
    issue(OP_READ, 1, 2, 0);
    check("R4 block erased", readData, 16'hFFFF);
    issue(OP_READ, 0, 0, 0);
    check("R4 other block kept", readData, 16'h0000);

    // Erase suspend
    progDone(2, 0, 16'h00FF);
    issue(OP_ERASE, 2, 0, 0);
    waitN(3);
    issue(OP_SUSP, 0, 0, 0);
    check("R5 erase suspended", status, 7'b0000011);
    waitN(20);
    check("R5 suspend holds", status, 7'b0000011);
    issue(OP_READ, 0, 0, 0);
    issue(OP_READ, 2, 0, 0);
    check("R6 read of suspended block refused", readData, 16'h0000);
    issue(OP_PROG, 3, 1, 16'h0F0F);
    check("R6 prog in erase suspend busy", status, 7'b0000010);
    waitN(NP);
    check("R6 prog in erase suspend done", status, 7'b0000011);
    issue(OP_READ, 3, 1, 0);
    check("R6 prog other block", readData, 16'h0F0F);
    issue(OP_PROG, 2, 5, 16'h0000);
    check("R6 prog to suspended block refused", status, 7'b0010011);
    issue(OP_CLR, 0, 0, 0);
    check("R12 clear keeps suspend", status, 7'b0000011);
    issue(OP_SUSP, 0, 0, 0);
    check("R9 double suspend ignored", status, 7'b0000011);
    issue(OP_RESUME, 0, 0, 0);
    check("R5 resumed busy", status, 7'b0000000);
    waitN(NE - 3 - 1);
    check("R5 remaining count busy", status[0], 0);
    waitN(1);
    check("R5 remaining count done", status, 7'b0000001);
    issue(OP_READ, 2, 0, 0);
    check("R4 suspended erase finished", readData, 16'hFFFF);
    issue(OP_READ, 2, 5, 0);
    check("R6 refused prog left no trace", readData, 16'hFFFF);
    issue(OP_RESUME, 0, 0, 0);
    check("R9 resume idle ignored", status, 7'b0000001);
    issue(OP_SUSP, 0, 0, 0);
    check("R9 suspend idle ignored", status, 7'b0000001);

    // Program suspend
    issue(OP_PROG, 0, 1, 16'h0000);
    waitN(1);
    issue(OP_SUSP, 0, 0, 0);
    check("R7 program suspended", status, 7'b0000101);
    waitN(10);
    issue(OP_ERASE, 3, 0, 0);
    check("R7 erase refused", status, 7'b0001101);
    issue(OP_PROG, 3, 2, 16'h0000);
    check("R7 program refused", status, 7'b0011101);
    issue(OP_READ, 3, 1, 0);
    check("R7 read other word", readData, 16'h0F0F);
    issue(OP_READ, 0, 1, 0);
    check("R7 read suspended word refused", readData, 16'h0F0F);
    issue(OP_CLR, 0, 0, 0);
    issue(OP_RESUME, 0, 0, 0);
    waitN(NP - 1 - 1);
    check("R7 resumed busy", status[0], 0);
    waitN(1);
    check("R7 resumed done", status, 7'b0000001);
    issue(OP_READ, 0, 1, 0);
    check("R7 program committed", readData, 16'h0000);
    issue(OP_READ, 3, 2, 0);
    check("R7 refused program no trace", readData, 16'hFFFF);

    // Nested suspend
    issue(OP_ERASE, 1, 0, 0);
    waitN(2);
    issue(OP_SUSP, 0, 0, 0);
    issue(OP_PROG, 3, 3, 16'h3333);
    issue(OP_SUSP, 0, 0, 0);
    check("R8 both suspended", status, 7'b0000111);
    issue(OP_RESUME, 0, 0, 0);
    check("R8 program resumed first", status, 7'b0000010);
    waitN(NP - 1);
    check("R8 program still busy", status, 7'b0000010);
    waitN(1);
    check("R8 program done erase suspended", status, 7'b0000011);
    issue(OP_RESUME, 0, 0, 0);
    waitN(NE - 2 - 1);
    check("R8 erase busy", status, 7'b0000000);
    waitN(1);
    check("R8 erase done", status, 7'b0000001);
    issue(OP_READ, 3, 3, 0);
    check("R8 nested program data", readData, 16'h3333);

    // Commands during a running operation
    issue(OP_ERASE, 0, 0, 0);
    issue(OP_PROG, 2, 2, 16'h0000);
    check("R13 prog during erase refused", status, 7'b0010000);
    issue(OP_ERASE, 1, 0, 0);
    check("R13 erase during erase refused", status, 7'b0011000);
    waitReady();
    check("R13 running erase intact", status, 7'b0011001);
    issue(OP_READ, 0, 1, 0);
    check("R13 erase completed", readData, 16'hFFFF);
    issue(OP_CLR, 0, 0, 0);

    // Supply lockout
    vppOk = 1'b0;
    issue(OP_PROG, 2, 2, 16'h0000);
    check("R10 prog low supply", status, 7'b0100001);
    issue(OP_ERASE, 3, 0, 0);
    check("R10 erase low supply", status, 7'b0100001);
    vppOk = 1'b1;
    issue(OP_READ, 3, 1, 0);
    check("R10 erase blocked", readData, 16'h0F0F);
    issue(OP_CLR, 0, 0, 0);
    issue(OP_PROG, 2, 2, 16'h0000);
    waitN(1);
    vppOk = 1'b0;
    waitN(1);
    check("R10 abort status", status, 7'b0100001);
    vppOk = 1'b1;
    issue(OP_READ, 2, 2, 0);
    check("R10 abort no write", readData, 16'hFFFF);
    progDone(2, 3, 16'hAAAA);
    check("R12 error sticky", status, 7'b0100001);
    issue(OP_CLR, 0, 0, 0);
    check("R12 cleared", status, 7'b0000001);

    // Locking
    issue(OP_LOCK, 3, 0, 0);
    issue(OP_PROG, 3, 4, 16'h0000);
    check("R11 prog locked", status, 7'b1000001);
    issue(OP_ERASE, 3, 0, 0);
    check("R11 erase locked", status, 7'b1000001);
    issue(OP_READ, 3, 4, 0);
    check("R11 locked word kept", readData, 16'hFFFF);
    issue(OP_UNLOCK, 3, 0, 0);
    issue(OP_PROG, 3, 4, 16'h5555);
    check("R11 unlock immediate", status, 7'b1000000);
    waitReady();
    issue(OP_READ, 3, 4, 0);
    check("R11 program after unlock", readData, 16'h5555);
    issue(OP_CLR, 0, 0, 0);

    // Constrained random phase against a bench model
    begin
      int seedDummy;
      seedDummy = $urandom(32'h5EED);
    end
    for (int b = 0; b < NB; b++) begin
      modelLock[b] = 1'b0;
      for (int w = 0; w < NW; w++) begin
        issue(OP_READ, b, w, 0);
        model[b][w] = readData;
      end
    end
    for (int it = 0; it < 120; it++) begin
      int op, blk, wd;
      logic [DW-1:0] d;
      logic vpp;
      op  = int'($urandom_range(0, 4));
      blk = int'($urandom_range(0, NB - 1));
      wd  = int'($urandom_range(0, NW - 1));
      d   = DW'($urandom);
      vpp = ($urandom_range(0, 7) != 0);
      issue(OP_CLR, 0, 0, 0);
      case (op)
        0: begin
          issue(OP_READ, blk, wd, 0);
          check("R2 random read", readData, model[blk][wd]);
        end
        1, 2: begin
          vppOk = vpp;
          issue(op == 1 ? OP_PROG : OP_ERASE, blk, wd, d);
          vppOk = 1'b1;
          waitReady();
          check(op == 1 ? "R2 random prog status" : "R4 random erase status",
                status, refusedStatus(vpp, modelLock[blk]));
          if (vpp && !modelLock[blk]) begin
            if (op == 1) model[blk][wd] = model[blk][wd] & d;
            else for (int w = 0; w < NW; w++) model[blk][w] = '1;
          end
        end
        default: begin
          issue(op == 3 ? OP_LOCK : OP_UNLOCK, blk, 0, 0);
          modelLock[blk] = (op == 3);
          check("R11 random lock status", status, 7'b0000001);
        end
      endcase
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule